// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

The block is a register-mapped timer with several independent 32-bit down-counters. Each channel holds a control word, an interval value used for reloads, and a live count that software can read at any time. A channel advances on tick-enable pulses from one of four time sources, after a per-channel power-of-two prescaler. When a channel's count runs out, it raises a sticky status bit. It then either reloads and continues (periodic) or stops (single-shot). All channels share one interrupt-enable word, one status word and one interrupt output.

Software programs a channel by writing the interval and then writing the control word with both the run and load bits set. Inverting the count gives a rising timestamp. Stopping a channel is not immediate: the channel keeps counting for two further ticks of its selected source before it halts. Software clears status bits by writing ones to them.

Top module: `cdt_timer`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: The address map is: interrupt enable at 0x00, status at 0x04, and for channel n the control word at 0x10*n+0x10, the interval at 0x10*n+0x14 and the count at 0x10*n+0x18. Control bits are: bit 0 run, bit 1 load, bits 3:2 source select, bits 6:4 prescale exponent, bit 7 single-shot. The control word and interval read back as written, except that the load bit always reads zero.
- R3: Writing the control word with run and load both set copies the interval into the count. The count then drops by one on each prescaled tick.
- R4: A prescale exponent p makes the count drop once per 2^p ticks of the selected source, counted from the start write. The first drop comes on the 2^p-th source tick.
- R5: Only `src_tick[s]` advances the channel, where s is its source-select field. Pulses on the other three sources leave its count unchanged.
- R6: In periodic mode (bit 7 clear), a prescaled tick that finds the count at 1 or 0 sets the channel's status bit, reloads the interval, and leaves the channel running. An interval of N therefore gives one event every N ticks.
- R7: In single-shot mode, a prescaled tick that finds the count at 1 or 0 sets the status bit, leaves the count at 0, stops the channel and clears its run bit in the control readback.
- R8: After a control write with run clear, a running channel still counts on the next two pulses of its selected source, then holds its count.
- R9: Status bit n (for channel n) clears when a one is written to it. A written zero leaves it unchanged. An event in the same cycle as the clear leaves the bit set.
- R10: `irq` is high exactly when some channel n has both status bit n and enable bit n set.
- R11: A control write with run set and load clear restarts a stopped channel from its held count.
- R12: Channels are independent: ticks, writes and events of one channel do not alter another channel's count or status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| src_tick | input | 4 | Tick-enable pulses, one per time source |
| irq | output | 1 | Combined interrupt request |

## Verification
A broken prescaler or decrement shows up in the count readback on the first source tick where the expected and actual division disagree. The sweep therefore reads the count after every single tick, for several prescale settings. A wrong stop-drain counter shows up within three source ticks of the disable write: the count either freezes too early or keeps falling. Reload and single-shot faults appear as a count or status mismatch on the tick right after the count reaches one. Status and mask faults appear on `irq` one cycle after the offending write or event.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int SRC_N      = 4;
  localparam int OFF_IEN    = 'h00;
  localparam int OFF_STAT   = 'h04;
  localparam int CH_BASE    = 'h10;
  localparam int CH_STRIDE  = 'h10;
  localparam int OFF_CTL    = 'h0;
  localparam int OFF_IVL    = 'h4;
  localparam int OFF_CNT    = 'h8;

  // control word layout, msb first: single(7) div(6:4) src(3:2) load(1) run(0)
  typedef struct packed {
    logic       single;
    logic [2:0] div;
    logic [1:0] src;
    logic       load;
    logic       run;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam int DIV_W = 3;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             src_pulse,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PC_W = (1 << DIV_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(div));
  end

  assign tick = src_pulse && ((pc_q & mask) == mask);

  always_comb begin
    pc_d = pc_q;
    if (clr)            pc_d = '0;
    else if (src_pulse) pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel import cdt_pkg::*; #(
  parameter int CNT_W       = 32,
  parameter int DRAIN_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             ctl_we,
  input  logic             ivl_we,
  input  logic [CNT_W-1:0] wdata,
  output ctl_t             ctl_q,
  output logic [CNT_W-1:0] ivl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_q,
  output logic             evt
);
  localparam int DR_W = $clog2(DRAIN_TICKS + 1);

  ctl_t             ctl_d, wctl;
  logic [CNT_W-1:0] ivl_d, cnt_d;
  logic             active_d, pend_q, pend_d;
  logic [DR_W-1:0]  drain_q, drain_d;
  logic             src_hit, pre_tick, step, at_end, ps_clr;

  assign wctl    = ctl_t'(wdata[CTL_W-1:0]);
  assign src_hit = src_tick[ctl_q.src];
  assign ps_clr  = !active_q || ctl_we;

  cdt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ps_clr),
    .src_pulse (src_hit),
    .div       (ctl_q.div),
    .tick      (pre_tick)
  );

  assign step   = active_q && !ctl_we && pre_tick;
  assign at_end = (cnt_q[CNT_W-1:1] == '0);
  assign evt    = step && at_end;

  always_comb begin
    ctl_d    = ctl_q;
    ivl_d    = ivl_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    pend_d   = pend_q;
    drain_d  = drain_q;
    if (ivl_we) ivl_d = wdata;
    if (ctl_we) begin
      ctl_d      = wctl;
      ctl_d.load = 1'b0;
      if (wctl.run) begin
        active_d = 1'b1;
        pend_d   = 1'b0;
        drain_d  = '0;
        if (wctl.load) cnt_d = ivl_q;
      end else if (active_q && !pend_q) begin
        pend_d  = 1'b1;
        drain_d = '0;
      end
    end else if (active_q) begin
      if (step) begin
        if (at_end) begin
          if (ctl_q.single) begin
            cnt_d     = '0;
            active_d  = 1'b0;
            pend_d    = 1'b0;
            ctl_d.run = 1'b0;
          end else begin
            cnt_d = ivl_q;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      if (pend_q && src_hit && active_d) begin
        if (drain_q == DR_W'(DRAIN_TICKS - 1)) begin
          active_d = 1'b0;
          pend_d   = 1'b0;
        end else begin
          drain_d = drain_q + DR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      ivl_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      drain_q  <= '0;
    end else begin
      ctl_q    <= ctl_d;
      ivl_q    <= ivl_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
      pend_q   <= pend_d;
      drain_q  <= drain_d;
    end
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           ien_we,
  input  logic           stat_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] ien_q,
  output logic [NCH-1:0] stat_q,
  output logic           irq
);
  logic [NCH-1:0] ien_d, stat_d, clr_mask;

  assign clr_mask = stat_we ? wbits : '0;

  always_comb begin
    ien_d  = ien_we ? wbits : ien_q;
    stat_d = (stat_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      ien_q  <= ien_d;
      stat_q <= stat_d;
    end
  end

  assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer import cdt_pkg::*; #(
  parameter int NUM_CH      = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int DRAIN_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_N-1:0]  src_tick,
  output logic              irq
);
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_all, ivl_all;
  ctl_t [NUM_CH-1:0]             ctl_all;
  logic [NUM_CH-1:0]             act_all, evt_all, single_all;
  logic [NUM_CH-1:0]             ien_q, stat_q;
  logic                          ien_hit, stat_hit;

  assign ien_hit  = bus_addr == ADDR_W'(OFF_IEN);
  assign stat_hit = bus_addr == ADDR_W'(OFF_STAT);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = CH_BASE + g * CH_STRIDE;
    logic ctl_we, ivl_we;
    assign ctl_we = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_CTL));
    assign ivl_we = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_IVL));

    cdt_channel #(.CNT_W(DATA_W), .DRAIN_TICKS(DRAIN_TICKS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .ctl_we   (ctl_we),
      .ivl_we   (ivl_we),
      .wdata    (bus_wdata),
      .ctl_q    (ctl_all[g]),
      .ivl_q    (ivl_all[g]),
      .cnt_q    (cnt_all[g]),
      .active_q (act_all[g]),
      .evt      (evt_all[g])
    );
    assign single_all[g] = ctl_all[g].single;
  end

  cdt_irq #(.NCH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_all),
    .ien_we  (bus_wr && ien_hit),
    .stat_we (bus_wr && stat_hit),
    .wbits   (bus_wdata[NUM_CH-1:0]),
    .ien_q   (ien_q),
    .stat_q  (stat_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (ien_hit)  bus_rdata = DATA_W'(ien_q);
    if (stat_hit) bus_rdata = DATA_W'(stat_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFF_CTL)) bus_rdata = DATA_W'(ctl_all[i]);
      if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFF_IVL)) bus_rdata = ivl_all[i];
      if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFF_CNT)) bus_rdata = cnt_all[i];
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk import cdt_pkg::*; #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          irq,
  input logic [NUM_CH-1:0]             ien_q,
  input logic [NUM_CH-1:0]             stat_q,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_all,
  input logic [NUM_CH-1:0][DATA_W-1:0] ivl_all,
  input logic [NUM_CH-1:0]             act_all,
  input logic [NUM_CH-1:0]             evt_all,
  input logic [NUM_CH-1:0]             single_all
);
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFF_STAT)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r9_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !$past(stat_q[g])) |-> $past(evt_all[g]));

    a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_all[g] && !bus_wr) |=> (cnt_all[g] == $past(cnt_all[g])));

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (act_all[g] && !bus_wr && cnt_all[g] > DATA_W'(1)) |=>
        (cnt_all[g] == $past(cnt_all[g]) || cnt_all[g] == $past(cnt_all[g]) - DATA_W'(1)));

    a_r7_single_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_all[g] && single_all[g] && !bus_wr) |=> !act_all[g]);

    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_all[g] && !single_all[g] && !bus_wr) |=> (cnt_all[g] == $past(ivl_all[g])));
  end
endmodule

bind cdt_timer cdt_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .irq        (irq),
  .ien_q      (ien_q),
  .stat_q     (stat_q),
  .cnt_all    (cnt_all),
  .ivl_all    (ivl_all),
  .act_all    (act_all),
  .evt_all    (evt_all),
  .single_all (single_all)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  logic        clk, rst_n, bus_wr, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, v;
  logic [3:0]  src_tick;
  int          total, bad;
  bit          done;

  cdt_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] ca(int ch, int off);
    return 8'(16 * ch + 16 + off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] tk = 4'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; src_tick = 4'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(int s, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_tick = 4'(1 << s);
      @(negedge clk); src_tick = 4'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 'h30; a += 4) begin
      rd(8'(a), v); chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 readback, load bit reads zero
    wr(ca(0, 0), 32'hFE);
    rd(ca(0, 0), v); chk("R2 ctl readback", v, 32'hFC);
    wr(ca(0, 4), 32'hDEADBEEF);
    rd(ca(0, 4), v); chk("R2 interval readback", v, 32'hDEADBEEF);
    wr(ca(0, 0), 32'h0);

    // R3/R4 prescale sweep on source 1
    wr(ca(0, 4), 32'd20);
    for (int p = 0; p < 4; p++) begin
      wr(ca(0, 0), 32'(3 | (1 << 2) | (p << 4)));
      rd(ca(0, 8), v); chk("R3 load", v, 32'd20);
      for (int t = 1; t <= (4 << p); t++) begin
        tick(1, 1);
        rd(ca(0, 8), v); chk("R4 prescaled count", v, 32'(20 - (t >> p)));
      end
    end

    // R5 unselected sources ignored
    wr(ca(0, 4), 32'd50);
    wr(ca(0, 0), 32'h07);
    tick(0, 3); tick(2, 3); tick(3, 3);
    rd(ca(0, 8), v); chk("R5 other sources", v, 32'd50);
    tick(1, 1);
    rd(ca(0, 8), v); chk("R5 selected source", v, 32'd49);

    // R8 stop drains two source ticks
    tick(1, 4);
    wr(ca(0, 0), 32'h04);
    rd(ca(0, 8), v); chk("R8 at disable", v, 32'd45);
    rd(ca(0, 0), v); chk("R8 run bit", v, 32'h04);
    tick(1, 1); rd(ca(0, 8), v); chk("R8 drain 1", v, 32'd44);
    tick(1, 1); rd(ca(0, 8), v); chk("R8 drain 2", v, 32'd43);
    tick(1, 5); rd(ca(0, 8), v); chk("R8 held", v, 32'd43);

    // R11 resume without load
    wr(ca(0, 0), 32'h05);
    tick(1, 2); rd(ca(0, 8), v); chk("R11 resume", v, 32'd41);

    // R6 periodic reload
    wr(ca(0, 4), 32'd3);
    wr(ca(0, 0), 32'h07);
    wr(8'h04, 32'hFFFF_FFFF);
    for (int t = 1; t <= 9; t++) begin
      tick(1, 1);
      rd(ca(0, 8), v); chk("R6 periodic count", v, 32'(3 - (t % 3)));
      rd(8'h04, v);    chk("R6 periodic status", v, (t % 3 == 0) ? 32'h1 : 32'h0);
      if (t % 3 == 0) wr(8'h04, 32'h1);
    end

    // R10 masking
    tick(1, 3);
    chk("R10 masked", 32'(irq), 32'h0);
    wr(8'h00, 32'h1); chk("R10 enabled", 32'(irq), 32'h1);
    wr(8'h00, 32'h2); chk("R10 other bit", 32'(irq), 32'h0);
    wr(8'h00, 32'h1);

    // R9 write-one-to-clear, set wins
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R9 zero write", v, 32'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R9 clear", v, 32'h0);
    chk("R9 irq after clear", 32'(irq), 32'h0);
    tick(1, 2);
    rd(ca(0, 8), v); chk("R6 before end", v, 32'd1);
    wr(8'h04, 32'h1, 4'b0010);
    rd(8'h04, v); chk("R9 set wins", v, 32'h1);
    rd(ca(0, 8), v); chk("R6 reload", v, 32'd3);

    // R7 single-shot
    wr(ca(0, 4), 32'd2);
    wr(ca(0, 0), 32'h87);
    wr(8'h04, 32'h1);
    tick(1, 1);
    rd(ca(0, 8), v); chk("R7 count", v, 32'd1);
    rd(8'h04, v);    chk("R7 no early status", v, 32'h0);
    tick(1, 1);
    rd(ca(0, 8), v); chk("R7 reaches zero", v, 32'd0);
    rd(8'h04, v);    chk("R7 status", v, 32'h1);
    rd(ca(0, 0), v); chk("R7 run cleared", v, 32'h84);
    wr(8'h04, 32'h1);
    tick(1, 4);
    rd(ca(0, 8), v); chk("R7 stays stopped", v, 32'd0);
    rd(8'h04, v);    chk("R7 single event", v, 32'h0);

    // R12 channel independence
    wr(ca(1, 4), 32'd5);
    wr(ca(1, 0), 32'h0B);
    tick(1, 3);
    rd(ca(1, 8), v); chk("R12 ch1 ignores src1", v, 32'd5);
    tick(2, 4);
    rd(ca(1, 8), v); chk("R12 ch1 count", v, 32'd1);
    tick(2, 1);
    rd(ca(1, 8), v); chk("R12 ch1 reload", v, 32'd5);
    rd(8'h04, v);    chk("R12 ch1 status", v, 32'h2);
    rd(ca(0, 8), v); chk("R12 ch0 untouched", v, 32'd0);
    chk("R10 ch1 masked", 32'(irq), 32'h0);
    wr(8'h00, 32'h2);
    chk("R10 ch1 enabled", 32'(irq), 32'h1);

    finish_run();
  end
endmodule